// File: doc/BRIEF.md
# Multithreaded Group Issue Scheduler

This block keeps the contexts of up to 48 thread groups that share one in-order pipeline, and picks which of them issues each cycle. A new group arrives through a spawn request carrying its start program counter, screen position and global bank selector. It receives a group ID and joins a first-in first-out wait queue. Queued groups move into a bounded set of 20 active slots, one group per cycle, in the order they arrived.

Each cycle a round-robin arbiter over the active slots picks one group whose memory or lock stall flag is clear. It presents that group's ID and stored context to instruction fetch. When the last live thread of an active group exits, the context is released and its slot is refilled from the head of the queue. The pipeline writes program counters back by group ID.

A group ID stays bound to its context from spawn to release, including while the group moves from the queue into a slot. Memory completions can therefore find the group at any time.

Top module: `grp_issue_sched`

## Requirements
- R1: While reset is asserted and after its release, `issue_valid` is 0 and `spawn_ready` is 1.
- R2: A spawn is accepted in a cycle where `spawn_valid` and `spawn_ready` are both 1. It receives the lowest unused group ID, shown on `spawn_gid` in that cycle. `spawn_ready` is 0 exactly when all 48 IDs are in use.
- R3: At most 20 groups are active at once. A group that has been accepted but has no slot never issues.
- R4: While the queue holds a group and a slot is free, one group per cycle moves from the queue into the lowest-numbered free slot. Groups are taken in acceptance order. A group accepted at a clock edge becomes eligible to move at the following edge.
- R5: At most one group issues per cycle. The arbiter searches slots in increasing index starting at a pointer and wrapping around. After a grant to slot s, the pointer becomes s+1 (mod 20). The pointer does not move in a cycle with no grant.
- R6: Bit g of `stall_vec` set keeps group ID g from issuing, and the search passes on to the next ready slot.
- R7: `issue_x`, `issue_y` and `issue_bank` return the values given at spawn for the issued group.
- R8: `pc_wr_valid` stores `pc_wr_pc` as the program counter of an in-use group `pc_wr_gid`. `issue_pc` shows the latest stored value, or the spawn value if none has been stored. Writes to unused IDs are dropped.
- R9: A spawned group starts with liveness mask 4'b1111, shown on `issue_live`. An exit on an active group clears the liveness bits set in `exit_mask`. When all bits are clear, the ID and the slot are released at that edge.
- R10: An exit naming a group that is queued or unused has no effect.
- R11: `issue_valid` is 0 in any cycle in which no active group is free of stall.
- R12: A group issues with the same ID it was given at spawn, also after moving from the queue into a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spawn_valid | input | 1 | Spawn request present |
| spawn_ready | output | 1 | A free group ID exists |
| spawn_gid | output | 6 | ID given to a spawn accepted this cycle |
| spawn_pc | input | 10 | Start program counter |
| spawn_x | input | 8 | Screen X position |
| spawn_y | input | 8 | Screen Y position |
| spawn_bank | input | 2 | Global register bank selector |
| stall_vec | input | 48 | Per-ID stall flag, bit g for ID g |
| exit_valid | input | 1 | Thread exit event |
| exit_gid | input | 6 | Group whose threads exit |
| exit_mask | input | 4 | Threads that exit, bit i for thread i |
| pc_wr_valid | input | 1 | Program counter update |
| pc_wr_gid | input | 6 | Group whose counter is updated |
| pc_wr_pc | input | 10 | New program counter |
| issue_valid | output | 1 | A group issues this cycle |
| issue_gid | output | 6 | ID of the issuing group |
| issue_pc | output | 10 | Its program counter |
| issue_x | output | 8 | Its screen X |
| issue_y | output | 8 | Its screen Y |
| issue_bank | output | 2 | Its global bank |
| issue_live | output | 4 | Its liveness mask |

## Verification
Some properties are checked on every cycle. An issued group must hold a live ID and have its stall bit clear. The grant is one-hot and falls on the pointer slot whenever that slot is ready, and there is no grant only when no slot is ready. Every cycle with a queued group and a free slot adds one active group. Exits reach only in-use contexts, and a final exit frees the ID at the next edge. Other behaviour needs the bench's scenarios against a reference model: the exact rotation of grants, the lowest-free choice of IDs and slots, first-in first-out promotion, and the stored program counter, position and liveness values. The same holds for ignored exits on queued groups and for back-pressure once all 48 IDs are taken.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int unsigned PC_W   = 10;
  localparam int unsigned POS_W  = 8;
  localparam int unsigned BANK_W = 2;
  localparam int unsigned LANES  = 4;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [POS_W-1:0]  x;
    logic [POS_W-1:0]  y;
    logic [BANK_W-1:0] bank;
    logic [LANES-1:0]  live;
  } ctx_t;
endpackage

// File: rtl/gis_wait_fifo.sv
module gis_wait_fifo #(
  parameter int unsigned DEPTH = 48,
  parameter int unsigned W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + PTR_W'(1);
    if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + PTR_W'(1);
    if (push && !pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (pop && !push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end

  assign head  = mem_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  // R4: queue never written beyond its depth nor read while empty
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !pop));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/gis_rr_arbiter.sv
module gis_rr_arbiter #(
  parameter int unsigned N = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic                 gnt_valid,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int unsigned IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [N-1:0]     gnt;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    gnt       = '0;
    for (int unsigned i = 0; i < N; i++) begin
      int unsigned s;
      s = int'(ptr_q) + i;
      if (s >= N) s = s - N;
      if (!gnt_valid && req[s]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IDX_W'(s);
      end
    end
    if (gnt_valid) gnt[gnt_idx] = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (gnt_valid) ptr_d = (gnt_idx == LAST) ? '0 : gnt_idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R5: single grant, and the pointer slot wins whenever it requests
  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_rr_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req[ptr_q] |-> (gnt_valid && gnt_idx == ptr_q));
  // R6: a grant only ever lands on a requesting slot
  p_grant_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_idx]);
  // R11: no grant only when nobody requests
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> (req == '0));
endmodule

// File: rtl/gis_ctx_table.sv
module gis_ctx_table
  import gis_pkg::*;
#(
  parameter int unsigned NUM_CTX = 48,
  parameter int unsigned GID_W   = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  ctx_t               alloc_ctx,
  output logic [GID_W-1:0]   alloc_gid,
  output logic               any_free,
  output logic [NUM_CTX-1:0] used,
  input  logic [GID_W-1:0]   rd_gid,
  output ctx_t               rd_ctx,
  input  logic               pc_wr,
  input  logic [GID_W-1:0]   pc_gid,
  input  logic [PC_W-1:0]    pc_val,
  input  logic               dn_valid,
  input  logic [GID_W-1:0]   dn_gid,
  input  logic [LANES-1:0]   dn_mask,
  output logic               dn_last
);
  ctx_t               ctx_q [NUM_CTX];
  ctx_t               ctx_d [NUM_CTX];
  logic [NUM_CTX-1:0] ctx_en, use_q, use_d;
  logic [LANES-1:0]   dn_live;

  always_comb begin
    alloc_gid = '0;
    for (int g = NUM_CTX - 1; g >= 0; g--) begin
      if (!use_q[g]) alloc_gid = GID_W'(g);
    end
  end

  assign any_free = ~&use_q;
  assign used     = use_q;
  assign rd_ctx   = ctx_q[rd_gid];
  assign dn_live  = ctx_q[dn_gid].live & ~dn_mask;
  assign dn_last  = dn_valid && (dn_live == '0);

  always_comb begin
    use_d  = use_q;
    ctx_en = '0;
    for (int g = 0; g < NUM_CTX; g++) ctx_d[g] = ctx_q[g];
    if (pc_wr && use_q[pc_gid]) begin
      ctx_d[pc_gid].pc = pc_val;
      ctx_en[pc_gid]   = 1'b1;
    end
    if (dn_valid) begin
      ctx_d[dn_gid].live = dn_live;
      ctx_en[dn_gid]     = 1'b1;
      if (dn_live == '0) use_d[dn_gid] = 1'b0;
    end
    if (alloc) begin
      ctx_d[alloc_gid]  = alloc_ctx;
      ctx_en[alloc_gid] = 1'b1;
      use_d[alloc_gid]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) use_q <= '0;
    else        use_q <= use_d;
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NUM_CTX; g++) begin
      if (ctx_en[g]) ctx_q[g] <= ctx_d[g];
    end
  end

  // R2: an accepted spawn occupies its ID from the next edge on
  p_alloc_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> use_q[$past(alloc_gid)]);
  // R10: exits reaching the table name only in-use contexts
  p_exit_on_used_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> use_q[dn_gid]);
  // R9: the final exit releases the ID
  p_free_on_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_last |=> !use_q[$past(dn_gid)]);
endmodule

// File: rtl/grp_issue_sched.sv
module grp_issue_sched
  import gis_pkg::*;
#(
  parameter int unsigned NUM_CTX   = 48,
  parameter int unsigned NUM_SLOTS = 20,
  parameter int unsigned GID_W     = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spawn_valid,
  output logic               spawn_ready,
  output logic [GID_W-1:0]   spawn_gid,
  input  logic [PC_W-1:0]    spawn_pc,
  input  logic [POS_W-1:0]   spawn_x,
  input  logic [POS_W-1:0]   spawn_y,
  input  logic [BANK_W-1:0]  spawn_bank,
  input  logic [NUM_CTX-1:0] stall_vec,
  input  logic               exit_valid,
  input  logic [GID_W-1:0]   exit_gid,
  input  logic [LANES-1:0]   exit_mask,
  input  logic               pc_wr_valid,
  input  logic [GID_W-1:0]   pc_wr_gid,
  input  logic [PC_W-1:0]    pc_wr_pc,
  output logic               issue_valid,
  output logic [GID_W-1:0]   issue_gid,
  output logic [PC_W-1:0]    issue_pc,
  output logic [POS_W-1:0]   issue_x,
  output logic [POS_W-1:0]   issue_y,
  output logic [BANK_W-1:0]  issue_bank,
  output logic [LANES-1:0]   issue_live
);
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [GID_W:0] CTX_LIM = (GID_W + 1)'(NUM_CTX);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [NUM_SLOTS-1:0] slot_v_q, slot_v_d;
  logic [GID_W-1:0]     slot_gid_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] req, ex_hit;
  logic [SLOT_W-1:0]    prom_slot, gnt_idx;
  logic                 slot_free_any, promote, gnt_valid;
  logic                 fifo_empty, spawn_fire, ex_act, pc_act, dn_last;
  logic [GID_W-1:0]     fifo_head, alloc_gid;
  logic [NUM_CTX-1:0]   used;
  ctx_t                 new_ctx, rd_ctx;

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign req[s]    = slot_v_q[s] && !stall_vec[slot_gid_q[s]];
      assign ex_hit[s] = slot_v_q[s] && (slot_gid_q[s] == exit_gid);
    end
  endgenerate

  assign ex_act     = exit_valid && ({1'b0, exit_gid} < CTX_LIM) && (|ex_hit);
  assign pc_act     = pc_wr_valid && ({1'b0, pc_wr_gid} < CTX_LIM);
  assign spawn_fire = spawn_valid && spawn_ready;
  assign spawn_gid  = alloc_gid;
  assign new_ctx    = '{pc: spawn_pc, x: spawn_x, y: spawn_y,
                        bank: spawn_bank, live: '1};

  always_comb begin
    prom_slot     = '0;
    slot_free_any = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!slot_v_q[i]) begin
        prom_slot     = SLOT_W'(i);
        slot_free_any = 1'b1;
      end
    end
  end

  assign promote = !fifo_empty && slot_free_any;

  always_comb begin
    slot_v_d = slot_v_q;
    if (ex_act && dn_last) slot_v_d = slot_v_q & ~ex_hit;
    if (promote) slot_v_d[prom_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) slot_v_q <= '0;
    else        slot_v_q <= slot_v_d;
  end

  always_ff @(posedge clk) begin
    if (promote) slot_gid_q[prom_slot] <= fifo_head;
  end

  gis_wait_fifo #(.DEPTH(NUM_CTX), .W(GID_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_i),
    .push      (spawn_fire),
    .push_data (alloc_gid),
    .pop       (promote),
    .head      (fifo_head),
    .empty     (fifo_empty)
  );

  gis_rr_arbiter #(.N(NUM_SLOTS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_i),
    .req       (req),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  gis_ctx_table #(.NUM_CTX(NUM_CTX), .GID_W(GID_W)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_i),
    .alloc     (spawn_fire),
    .alloc_ctx (new_ctx),
    .alloc_gid (alloc_gid),
    .any_free  (spawn_ready),
    .used      (used),
    .rd_gid    (issue_gid),
    .rd_ctx    (rd_ctx),
    .pc_wr     (pc_act),
    .pc_gid    (pc_wr_gid),
    .pc_val    (pc_wr_pc),
    .dn_valid  (ex_act),
    .dn_gid    (exit_gid),
    .dn_mask   (exit_mask),
    .dn_last   (dn_last)
  );

  assign issue_valid = gnt_valid;
  assign issue_gid   = slot_gid_q[gnt_idx];
  assign issue_pc    = rd_ctx.pc;
  assign issue_x     = rd_ctx.x;
  assign issue_y     = rd_ctx.y;
  assign issue_bank  = rd_ctx.bank;
  assign issue_live  = rd_ctx.live;

  // R3: active slots never outnumber live contexts
  p_active_bound_r3: assert property (@(posedge clk) disable iff (!rst_i)
    $countones(slot_v_q) <= $countones(used));
  // R4: a waiting group fills a free slot at the next edge
  p_refill_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (promote && !(ex_act && dn_last)) |=>
      ($countones(slot_v_q) == $past($countones(slot_v_q)) + 1));
  // R6: a stalled group is never presented to fetch
  p_issue_skip_stall_r6: assert property (@(posedge clk) disable iff (!rst_i)
    issue_valid |-> !stall_vec[issue_gid]);
  // R12: the issued ID always names a live context
  p_issue_live_r12: assert property (@(posedge clk) disable iff (!rst_i)
    issue_valid |-> used[issue_gid]);
  // R2: back-pressure only with every ID taken
  p_backpressure_r2: assert property (@(posedge clk) disable iff (!rst_i)
    !spawn_ready |-> (&used));
endmodule

// File: tb/grp_issue_sched_bench.sv
module grp_issue_sched_bench;
  localparam int NC = 48;
  localparam int NS = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spawn_valid, spawn_ready;
  logic [5:0]  spawn_gid;
  logic [9:0]  spawn_pc;
  logic [7:0]  spawn_x, spawn_y;
  logic [1:0]  spawn_bank;
  logic [47:0] stall_vec;
  logic        exit_valid;
  logic [5:0]  exit_gid;
  logic [3:0]  exit_mask;
  logic        pc_wr_valid;
  logic [5:0]  pc_wr_gid;
  logic [9:0]  pc_wr_pc;
  logic        issue_valid;
  logic [5:0]  issue_gid;
  logic [9:0]  issue_pc;
  logic [7:0]  issue_x, issue_y;
  logic [1:0]  issue_bank;
  logic [3:0]  issue_live;

  always #4 clk = ~clk;

  grp_issue_sched u_grp_issue_sched (
    .clk(clk), .rst_n(rst_n),
    .spawn_valid(spawn_valid), .spawn_ready(spawn_ready), .spawn_gid(spawn_gid),
    .spawn_pc(spawn_pc), .spawn_x(spawn_x), .spawn_y(spawn_y), .spawn_bank(spawn_bank),
    .stall_vec(stall_vec),
    .exit_valid(exit_valid), .exit_gid(exit_gid), .exit_mask(exit_mask),
    .pc_wr_valid(pc_wr_valid), .pc_wr_gid(pc_wr_gid), .pc_wr_pc(pc_wr_pc),
    .issue_valid(issue_valid), .issue_gid(issue_gid), .issue_pc(issue_pc),
    .issue_x(issue_x), .issue_y(issue_y), .issue_bank(issue_bank), .issue_live(issue_live)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  string ph = "R1";

  // reference model state
  bit         m_use [NC];
  logic [9:0] m_pc  [NC];
  logic [7:0] m_x   [NC];
  logic [7:0] m_y   [NC];
  logic [1:0] m_bank[NC];
  logic [3:0] m_live[NC];
  bit         m_sv  [NS];
  int         m_sg  [NS];
  int         m_q   [64];
  int         m_qh = 0, m_qn = 0, m_rr = 0;
  int         hist  [NC];

  // stimulus for the next cycle
  bit         b_sv, b_ev, b_pv;
  logic [9:0] b_spc, b_pp;
  logic [7:0] b_sx, b_sy;
  logic [1:0] b_sb;
  logic [47:0] b_st;
  int         b_eg, b_pg;
  logic [3:0] b_em;

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", ph, tag, act, exp);
    end
  endtask

  task automatic clr();
    b_sv = 0; b_ev = 0; b_pv = 0; b_spc = '0; b_pp = '0; b_sx = '0; b_sy = '0;
    b_sb = '0; b_st = '0; b_eg = 0; b_pg = 0; b_em = '0;
  endtask

  task automatic clr_hist();
    for (int g = 0; g < NC; g++) hist[g] = 0;
  endtask

  // one cycle: drive at negedge, compare before the edge, advance the model
  task automatic tick();
    int ps, hs, fs, esg;
    bit prom, er, fv;
    spawn_valid = b_sv; spawn_pc = b_spc; spawn_x = b_sx; spawn_y = b_sy;
    spawn_bank = b_sb; stall_vec = b_st; exit_valid = b_ev; exit_gid = 6'(b_eg);
    exit_mask = b_em; pc_wr_valid = b_pv; pc_wr_gid = 6'(b_pg); pc_wr_pc = b_pp;
    #1;
    er = 0; esg = 0;
    for (int g = NC - 1; g >= 0; g--) if (!m_use[g]) begin er = 1; esg = g; end
    fv = 0; fs = 0;
    for (int i = 0; i < NS; i++) begin
      int s;
      s = (m_rr + i) % NS;
      if (!fv && m_sv[s] && !b_st[m_sg[s]]) begin fv = 1; fs = s; end
    end
    chk("R11 issue_valid", issue_valid == fv, int'(issue_valid), int'(fv));
    if (fv && issue_valid) begin
      int g;
      g = m_sg[fs];
      hist[g]++;
      chk("R5 issue_gid", int'(issue_gid) == g, int'(issue_gid), g);
      chk("R8 issue_pc", issue_pc == m_pc[g], int'(issue_pc), int'(m_pc[g]));
      chk("R7 issue_x", issue_x == m_x[g], int'(issue_x), int'(m_x[g]));
      chk("R7 issue_y", issue_y == m_y[g], int'(issue_y), int'(m_y[g]));
      chk("R7 issue_bank", issue_bank == m_bank[g], int'(issue_bank), int'(m_bank[g]));
      chk("R9 issue_live", issue_live == m_live[g], int'(issue_live), int'(m_live[g]));
    end
    chk("R2 spawn_ready", spawn_ready == er, int'(spawn_ready), int'(er));
    if (er) chk("R2 spawn_gid", int'(spawn_gid) == esg, int'(spawn_gid), esg);
    // model update
    ps = -1;
    for (int s = NS - 1; s >= 0; s--) if (!m_sv[s]) ps = s;
    prom = (m_qn > 0) && (ps >= 0);
    hs = -1;
    if (b_ev && b_eg < NC)
      for (int s = 0; s < NS; s++) if (m_sv[s] && m_sg[s] == b_eg) hs = s;
    if (b_pv && b_pg < NC && m_use[b_pg]) m_pc[b_pg] = b_pp;
    if (hs >= 0) begin
      m_live[b_eg] = m_live[b_eg] & ~b_em;
      if (m_live[b_eg] == 4'h0) begin m_use[b_eg] = 0; m_sv[hs] = 0; end
    end
    if (prom) begin
      m_sv[ps] = 1; m_sg[ps] = m_q[m_qh]; m_qh = (m_qh + 1) % 64; m_qn--;
    end
    if (b_sv && er) begin
      m_use[esg] = 1; m_pc[esg] = b_spc; m_x[esg] = b_sx; m_y[esg] = b_sy;
      m_bank[esg] = b_sb; m_live[esg] = 4'hF;
      m_q[(m_qh + m_qn) % 64] = esg; m_qn++;
    end
    if (fv) m_rr = (fs + 1) % NS;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_exit(input int g, input logic [3:0] m);
    b_ev = 1; b_eg = g; b_em = m;
    tick();
    b_ev = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R5 watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    for (int g = 0; g < NC; g++) begin m_use[g] = 0; m_live[g] = '0; end
    for (int s = 0; s < NS; s++) begin m_sv[s] = 0; m_sg[s] = 0; end
    clr();
    rst_n = 1'b0;
    spawn_valid = 0; stall_vec = '0; exit_valid = 0; pc_wr_valid = 0;
    spawn_pc = '0; spawn_x = '0; spawn_y = '0; spawn_bank = '0;
    exit_gid = '0; exit_mask = '0; pc_wr_gid = '0; pc_wr_pc = '0;
    repeat (3) @(negedge clk);
    ph = "R1";
    chk("R1 issue_valid in reset", issue_valid == 1'b0, int'(issue_valid), 0);
    chk("R1 spawn_ready in reset", spawn_ready == 1'b1, int'(spawn_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle(3);

    // R3: thirty spawns, only the first twenty become active
    ph = "R3";
    for (int i = 0; i < 30; i++) begin
      b_sv = 1; b_spc = 10'(i * 3 + 1); b_sx = 8'(i); b_sy = 8'(100 + i); b_sb = 2'(i % 4);
      tick();
    end
    clr();
    clr_hist();
    idle(45);
    cnt = 0;
    for (int g = 0; g < NC; g++) if (hist[g] > 0) cnt++;
    chk("R3 distinct issuing groups", cnt == 20, cnt, 20);
    cnt = 0;
    for (int g = 20; g < NC; g++) cnt += hist[g];
    chk("R3 queued groups issued", cnt == 0, cnt, 0);

    // R4 / R12: freed slot goes to queue head, ID kept
    ph = "R4";
    clr_hist();
    do_exit(5, 4'hF);
    idle(30);
    chk("R12 head group 20 issued", hist[20] > 0, hist[20], 1);
    chk("R4 second in queue waits", hist[21] == 0, hist[21], 0);
    chk("R9 exited group silent", hist[5] == 0, hist[5], 0);

    // R10: exit naming a queued group is ignored
    ph = "R10";
    do_exit(25, 4'hF);
    do_exit(6, 4'hF);
    clr_hist();
    idle(30);
    chk("R10 group 21 promoted", hist[21] > 0, hist[21], 1);
    chk("R10 group 25 still queued", hist[25] == 0, hist[25], 0);
    do_exit(7, 4'hF);
    clr_hist();
    idle(30);
    chk("R10 queued group 22 promoted next", hist[22] > 0, hist[22], 1);

    // R9: partial exits keep the group alive
    ph = "R9";
    do_exit(0, 4'h1);
    idle(22);
    do_exit(0, 4'h6);
    clr_hist();
    idle(22);
    chk("R9 partly exited group issues", hist[0] > 0, hist[0], 1);
    do_exit(0, 4'h8);
    idle(22);

    // R6: only one unstalled group
    ph = "R6";
    b_st = ~(48'd1 << 3);
    clr_hist();
    idle(10);
    chk("R6 only group 3 issues", hist[3] == 10, hist[3], 10);
    // R11: all stalled
    ph = "R11";
    b_st = '1;
    clr_hist();
    idle(6);
    cnt = 0;
    for (int g = 0; g < NC; g++) cnt += hist[g];
    chk("R11 nothing issues", cnt == 0, cnt, 0);
    b_st = '0;

    // R8: counter writes, one to a live ID and one to a free ID
    ph = "R8";
    b_pv = 1; b_pg = 9; b_pp = 10'h3FF; tick();
    b_pg = 5; b_pp = 10'h155; tick();
    b_pv = 0;
    idle(25);

    // R2: fill all IDs, then back-pressure
    ph = "R2";
    for (int i = 0; i < 30; i++) begin
      b_sv = 1; b_spc = 10'(i + 500); b_sx = 8'(i * 7); b_sy = 8'(i); b_sb = 2'(i);
      tick();
    end
    chk("R2 full back-pressure", spawn_ready == 1'b0, int'(spawn_ready), 0);
    clr();

    // R5: constrained random traffic
    ph = "R5";
    for (int i = 0; i < 5000; i++) begin
      b_sv  = ($urandom % 2) == 0;
      b_spc = 10'($urandom); b_sx = 8'($urandom); b_sy = 8'($urandom); b_sb = 2'($urandom);
      b_st  = {16'($urandom), 32'($urandom)} & {16'($urandom), 32'($urandom)};
      b_ev  = ($urandom % 3) == 0;
      b_eg  = int'($urandom % NC);
      b_em  = 4'(($urandom % 15) + 1);
      b_pv  = ($urandom % 4) == 0;
      b_pg  = int'($urandom % NC);
      b_pp  = 10'($urandom);
      tick();
    end
    clr();
    idle(5);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule